// File: doc/BRIEF.md
# Bit-Addressable Discrete I/O Port

This block gives a processor bus access to a collection of single-bit discrete signals, with one bus address for each bit. The bus address is split into two fields. The three least significant bits choose one of eight bits within a bank. The bits above them choose the bank. Writes take the new bit value from data-bus bit 0 and change exactly one output latch. Reads return the chosen bit on data-bus bit 0, and every other read bit is zero. Software therefore sets, clears or tests any single discrete line with one bus access. There is no read-modify-write and no masking.

Three kinds of bank sit in the map, in ascending bank number:

- **Output banks.** These are write-only groups of eight latches that drive the output pins.
- **Input banks.** These are read-only 8:1 selectors over the input pins. The input pins may include status flags produced elsewhere, such as latched interrupt or button flags.
- **Capture bank.** This is a single bank of eight cells. A write to one of its addresses discards the bus data and stores the present level of an external asynchronous line, after two synchronizing flops, into the addressed cell. A read at the same address returns that cell.

Read results are registered. They appear one cycle after the read strobe, together with a hit flag that marks a read from a decoded bank.

Top module: `iop_bit_port`

## Requirements
- R1: Address bits [2:0] give the bit index within a bank, and bits [ADDR_W-1:3] give the bank number. Banks 0..N_OUT-1 are output banks. The next N_IN banks are input banks. The bank immediately after the input banks is the capture bank. Every higher bank number is unmapped.
- R2: A write to an output bank sets the addressed latch to bus_wdata[0]. Bits [DATA_W-1:1] of the write data are ignored. All other output bits keep their values. Output bank b, bit i drives out_bits[b*8+i].
- R3: A read of input bank k (bank number N_OUT+k), bit i, returns in_pins[k*8+i] on bus_rdata[0] in the cycle after the read strobe. bus_rdata[DATA_W-1:1] is zero.
- R4: A write to a capture-bank address stores the synchronized level of cap_in into the addressed cell and ignores bus_wdata entirely.
- R5: A read of capture-bank bit i returns cell i on bus_rdata[0] in the cycle after the read strobe.
- R6: cap_in passes through two flops before it is stored. A change of cap_in becomes visible to a capture write only at the third rising edge after the change, counting the first edge at which it is sampled.
- R7: Reset (rst_n low) clears all output latches, all capture cells, bus_rdata and rd_hit.
- R8: A read of an output-bank or unmapped address returns zero with rd_hit low. A write to an input-bank or unmapped address changes no output latch and no capture cell.
- R9: rd_hit is high in the cycle after a read strobe to an input-bank or capture-bank address, and low otherwise.
- R10: In any cycle not preceded by a read strobe, bus_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Bus word address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data; only bit 0 is used |
| bus_rdata | output | DATA_W | Registered read data; only bit 0 can be nonzero |
| rd_hit | output | 1 | Registered flag for a read of a decoded bank |
| in_pins | input | N_IN*8 | Discrete inputs and status flags read through the input banks |
| cap_in | input | 1 | Asynchronous line sampled by capture-bank writes |
| out_bits | output | N_OUT*8 | Output latch contents |

## Verification
The assertions assume that the bus never raises read and write strobes in the same cycle. Under that assumption, each strobe can be tied to exactly one registered effect. The bench's access tasks drive one strobe for one cycle and then drop it. Inputs are changed only at falling edges.

The properties also assume that in_pins is stable around a read. The bench sets the pin pattern before a read sequence and leaves it unchanged until the sequence ends.

cap_in is the one input that the block treats as asynchronous. The bench changes it deliberately in the same cycle as a capture write, in order to observe the synchronizer latency.

// File: rtl/iop_pkg.sv
package iop_pkg;
    localparam int BANK_BITS = 8;
    localparam int IDX_W     = 3;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_OUT  = 2'd1,
        KIND_IN   = 2'd2,
        KIND_CAP  = 2'd3
    } bank_kind_e;
endpackage

// File: rtl/iop_decode.sv
module iop_decode
    import iop_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int N_OUT  = 2,
    parameter int N_IN   = 4
) (
    input  logic [ADDR_W-1:0]       addr,
    output bank_kind_e              kind,
    output logic [ADDR_W-IDX_W-1:0] sel,
    output logic [IDX_W-1:0]        idx
);
    localparam int SEL_W   = ADDR_W - IDX_W;
    localparam int IN_BASE = N_OUT;
    localparam int CAP_NUM = N_OUT + N_IN;

    int bank;

    always_comb begin
        bank = int'(addr[ADDR_W-1:IDX_W]);
        idx  = addr[IDX_W-1:0];
        kind = KIND_NONE;
        sel  = '0;
        if (bank < N_OUT) begin
            kind = KIND_OUT;
            sel  = SEL_W'(bank);
        end else if (bank < CAP_NUM) begin
            kind = KIND_IN;
            sel  = SEL_W'(bank - IN_BASE);
        end else if (bank == CAP_NUM) begin
            kind = KIND_CAP;
        end
    end
endmodule

// File: rtl/iop_sync2.sv
module iop_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/iop_bit_bank.sv
module iop_bit_bank
    import iop_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 din,
    output logic [BANK_BITS-1:0] q
);
    typedef struct packed {
        logic [BANK_BITS-1:0] cells;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (we) bk_d.cells[idx] = din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign q = bk_q.cells;
endmodule

// File: rtl/iop_bit_port.sv
module iop_bit_port
    import iop_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int N_OUT  = 2,
    parameter int N_IN   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   rd_hit,
    input  logic [N_IN*8-1:0]      in_pins,
    input  logic                   cap_in,
    output logic [N_OUT*8-1:0]     out_bits
);
    localparam int SEL_W    = ADDR_W - IDX_W;
    localparam int IN_W     = N_IN * BANK_BITS;
    localparam int IN_IDX_W = (IN_W > 1) ? $clog2(IN_W) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              hit;
    } rd_t;

    bank_kind_e           kind;
    logic [SEL_W-1:0]     sel;
    logic [IDX_W-1:0]     idx;
    logic                 cap_s;
    logic [BANK_BITS-1:0] cap_cells;
    logic [IN_IDX_W-1:0]  in_flat;
    logic                 rd_bit;
    logic                 rd_ok;
    rd_t                  rd_d, rd_q;

    iop_decode #(.ADDR_W(ADDR_W), .N_OUT(N_OUT), .N_IN(N_IN)) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .sel  (sel),
        .idx  (idx)
    );

    generate
        for (genvar g = 0; g < N_OUT; g++) begin : g_out
            logic we_g;
            assign we_g = bus_wr && (kind == KIND_OUT) && (sel == SEL_W'(g));
            iop_bit_bank u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (we_g),
                .idx   (idx),
                .din   (bus_wdata[0]),
                .q     (out_bits[g*BANK_BITS +: BANK_BITS])
            );
        end
    endgenerate

    iop_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cap_in),
        .q     (cap_s)
    );

    logic cap_we;
    assign cap_we = bus_wr && (kind == KIND_CAP);

    iop_bit_bank u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cap_we),
        .idx   (idx),
        .din   (cap_s),
        .q     (cap_cells)
    );

    always_comb begin
        in_flat = IN_IDX_W'(int'(sel) * BANK_BITS + int'(idx));
        rd_bit  = 1'b0;
        rd_ok   = 1'b0;
        case (kind)
            KIND_IN: begin
                rd_bit = in_pins[in_flat];
                rd_ok  = 1'b1;
            end
            KIND_CAP: begin
                rd_bit = cap_cells[idx];
                rd_ok  = 1'b1;
            end
            default: ;
        endcase

        rd_d = '0;
        if (bus_rd) begin
            rd_d.rdata[0] = rd_bit;
            rd_d.hit      = rd_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;
    assign rd_hit    = rd_q.hit;
endmodule

// File: rtl/iop_chk.sv
module iop_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int N_OUT  = 2,
    parameter int N_IN   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic                 rd_hit,
    input logic [N_OUT*8-1:0]   out_bits
);
    localparam int FIRST_UNMAPPED = (N_OUT + N_IN + 1) * 8;
    localparam int FIRST_INPUT    = N_OUT * 8;

    logic unmapped_a;
    logic outbank_a;
    assign unmapped_a = int'(bus_addr) >= FIRST_UNMAPPED;
    assign outbank_a  = int'(bus_addr) <  FIRST_INPUT;

    // R3: only data bit 0 may carry a read result
    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:1] == '0);

    // R10 and R9: no strobe, no data and no hit
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0) && !rd_hit);

    // R2: at most one output bit moves per cycle
    p_one_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> $countones(out_bits ^ $past(out_bits)) <= 1);

    // R2: outputs hold without a write
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(out_bits));

    // R8: unmapped or output-bank reads never hit
    p_no_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (unmapped_a || outbank_a)) |=> !rd_hit && (bus_rdata == '0));

    // R9: mapped readable addresses always hit
    p_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !unmapped_a && !outbank_a) |=> rd_hit);

    // R8: writes outside output banks leave outputs alone
    p_wr_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !outbank_a) |=> $stable(out_bits));
endmodule

bind iop_bit_port iop_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_OUT  (N_OUT),
    .N_IN   (N_IN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .rd_hit    (rd_hit),
    .out_bits  (out_bits)
);

// File: tb/tb_iop_bit_port.sv
`timescale 1ns/1ps
module tb_iop_bit_port;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int N_OUT  = 2;
    localparam int N_IN   = 4;
    localparam int IN_BASE  = N_OUT * 8;           // 0x10
    localparam int CAP_BASE = (N_OUT + N_IN) * 8;  // 0x30

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [ADDR_W-1:0]    bus_addr = '0;
    logic                 bus_wr = 1'b0;
    logic                 bus_rd = 1'b0;
    logic [DATA_W-1:0]    bus_wdata = '0;
    logic [DATA_W-1:0]    bus_rdata;
    logic                 rd_hit;
    logic [N_IN*8-1:0]    in_pins = '0;
    logic                 cap_in = 1'b0;
    logic [N_OUT*8-1:0]   out_bits;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [N_OUT*8-1:0] exp_out = '0;
    logic [7:0]         exp_cap = '0;

    always #10 clk = ~clk;

    iop_bit_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_OUT(N_OUT), .N_IN(N_IN)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_hit(rd_hit),
        .in_pins(in_pins), .cap_in(cap_in), .out_bits(out_bits)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int addr, input logic [DATA_W-1:0] data);
        @(negedge clk);
        bus_addr  = ADDR_W'(addr);
        bus_wdata = data;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input int addr, output logic [DATA_W-1:0] d, output logic h);
        @(negedge clk);
        bus_addr = ADDR_W'(addr);
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        d = bus_rdata;
        h = rd_hit;
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] d;
        logic h;
        chk("R7 out_bits after reset", 32'(out_bits), 32'h0);
        chk("R7 rdata after reset", 32'(bus_rdata), 32'h0);
        chk("R7 rd_hit after reset", 32'(rd_hit), 32'h0);
        for (int i = 0; i < 8; i++) begin
            bus_read(CAP_BASE + i, d, h);
            chk("R7 R5 capture cell clear", 32'(d), 32'h0);
        end
    endtask

    task automatic t_out_single();
        bus_write(3, 16'h0001);  exp_out[3]  = 1'b1;
        chk("R2 set bank0 bit3", 32'(out_bits), 32'(exp_out));
        bus_write(15, 16'hFFFF); exp_out[15] = 1'b1;
        chk("R1 R2 set bank1 bit7", 32'(out_bits), 32'(exp_out));
        bus_write(3, 16'hFFFE);  exp_out[3]  = 1'b0;
        chk("R2 upper data ignored, bit3 cleared", 32'(out_bits), 32'(exp_out));
    endtask

    task automatic t_out_walk();
        logic [15:0] pat = 16'hB36D;
        for (int i = 0; i < 16; i++) begin
            bus_write(i, {15'h5A5A, pat[i]});
            exp_out[i] = pat[i];
        end
        chk("R2 walked pattern", 32'(out_bits), 32'(exp_out));
        for (int i = 0; i < 16; i += 5) begin
            bus_write(i, 16'(~exp_out[i]));
            exp_out[i] = ~exp_out[i];
            chk("R2 single toggle", 32'(out_bits), 32'(exp_out));
        end
    endtask

    task automatic t_in_read(input logic [31:0] pat);
        logic [DATA_W-1:0] d;
        logic h;
        in_pins = pat;
        for (int i = 0; i < 32; i++) begin
            bus_read(IN_BASE + i, d, h);
            chk("R3 R1 input bit", 32'(d), {31'h0, pat[i]});
            chk("R9 input hit", 32'(h), 32'h1);
        end
    endtask

    task automatic t_unmapped();
        logic [DATA_W-1:0] d;
        logic h;
        in_pins = 32'hFFFF_FFFF;
        bus_read(8'h40, d, h);
        chk("R8 unmapped read data", 32'(d), 32'h0);
        chk("R8 unmapped read hit", 32'(h), 32'h0);
        bus_read(8'hFF, d, h);
        chk("R8 top address read", {31'h0, h} | 32'(d), 32'h0);
        bus_read(5, d, h);
        chk("R8 output-bank read", {31'h0, h} | 32'(d), 32'h0);
        bus_write(8'h12, 16'h0001);
        bus_write(8'h40, 16'h0001);
        bus_write(8'hC3, 16'h0001);
        chk("R8 stray writes leave outputs", 32'(out_bits), 32'(exp_out));
        for (int i = 0; i < 8; i++) begin
            bus_read(CAP_BASE + i, d, h);
            chk("R8 stray writes leave capture", 32'(d), {31'h0, exp_cap[i]});
        end
    endtask

    task automatic t_capture();
        logic [DATA_W-1:0] d;
        logic h;
        @(negedge clk); cap_in = 1'b1;
        repeat (4) @(negedge clk);
        bus_write(CAP_BASE + 2, 16'h0000); exp_cap[2] = 1'b1;
        bus_read(CAP_BASE + 2, d, h);
        chk("R4 capture stores high, data ignored", 32'(d), 32'h1);
        chk("R9 capture hit", 32'(h), 32'h1);
        @(negedge clk); cap_in = 1'b0;
        repeat (4) @(negedge clk);
        bus_write(CAP_BASE + 5, 16'hFFFF); exp_cap[5] = 1'b0;
        bus_read(CAP_BASE + 5, d, h);
        chk("R4 capture stores low, data ignored", 32'(d), 32'h0);
        // R6: change cap_in at the same falling edge as the write
        @(negedge clk);
        cap_in    = 1'b1;
        bus_addr  = ADDR_W'(CAP_BASE + 6);
        bus_wdata = 16'h0001;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        exp_cap[6] = 1'b0;
        bus_read(CAP_BASE + 6, d, h);
        chk("R6 fresh change not yet synchronized", 32'(d), 32'h0);
        bus_write(CAP_BASE + 7, 16'h0000); exp_cap[7] = 1'b1;
        for (int i = 0; i < 8; i++) begin
            bus_read(CAP_BASE + i, d, h);
            chk("R5 capture readback", 32'(d), {31'h0, exp_cap[i]});
        end
    endtask

    task automatic t_idle();
        logic [DATA_W-1:0] d;
        logic h;
        in_pins = 32'hFFFF_FFFF;
        bus_read(IN_BASE, d, h);
        chk("R3 read of set pin", 32'(d), 32'h1);
        @(negedge clk);
        chk("R10 idle rdata zero", 32'(bus_rdata), 32'h0);
        chk("R9 idle hit low", 32'(rd_hit), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_out_single();
        t_out_walk();
        t_in_read(32'hA5C3_1E78);
        t_in_read(32'h5A3C_E187);
        t_capture();
        t_unmapped();
        t_idle();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule